// File: doc/BRIEF.md
# Indexed-Colour Display Register Block

This block is the memory-mapped control slave of an 8-bit indexed-colour display engine. A host reaches it through a simple valid/write/size handshake on a 21-bit byte address. It holds the active picture size, a 32-bit control word, the start-of-screen offset, the pointer position, a 256-entry RGB colour table, a 3-entry pointer colour table and a 512-word pointer bitmap. It hands the decoded fields and combinational table lookups to the pixel pipeline.

The picture size is kept in scaled form: the horizontal register counts groups of four pixels and the vertical register counts half-lines. Byte and halfword writes are done as a read-merge-write of the containing 32-bit word, so every register behaves as one word. The frame logic raises a level interrupt once per frame, and any register write drops it. Writing a dedicated address returns the whole block to its power-up contents. Video timing offsets accept writes and discard them.

Top module: `fbreg_ctrl`

## Requirements
- R1: After reset, width, height, control word, start-of-screen, pointer position, all tables and the interrupt are zero, and the read data and error outputs are low. Depth therefore reads as 1, blanking is off and the pointer is enabled.
- R2: A read of word address 0x000000 returns 0x00000010. A write there has no effect and raises no error.
- R3: A write of value V to 0x080118 sets the width to V[13:0]*4. A read there returns the width divided by 4.
- R4: A write of value V to 0x080150 sets the height to V[16:1], which is V/2 truncated. A read there returns the height times 2.
- R5: The control word at 0x080300 reads back all 32 bits. Bit 10 set forces blanking. Bit 23 set disables the pointer. Bits 22:20 select the depth: codes 0..7 give 1, 2, 4, 8, 15, 16, 0, 0.
- R6: Colour entry i sits at 0x080800 + 8*i and holds red in bits 23:16, green in 15:8 and blue in 7:0. Bits 31:24 are dropped on a write and read as zero. The pixel lookup port returns the 24-bit entry selected by the pixel index in the same cycle.
- R7: Pointer colour entry k (k = 0..2) sits at 0x080508 + 8*k with the same packing. Pointer bitmap word j (j = 0..511) sits at 0x081000 + 8*j and holds 16 bits, with the upper 16 bits reading zero. Both tables read back over the bus and through their lookup ports.
- R8: Start-of-screen at 0x080400 holds 32 bits. The pointer position at 0x080638 holds X in bits 23:12 and Y in bits 11:0, and the upper byte reads as zero. Both registers read back.
- R9: The size input selects the write width: 0 is byte, 1 is halfword, 2 or 3 is word. Sub-word write data sits in the low bits of the write data. The byte lane is address bits 1:0 and the halfword lane is address bit 1. Only the addressed lane of the stored word changes.
- R10: A byte or halfword read returns the addressed lane of the word, shifted to bit 0 and zero-extended.
- R11: Any write to 0x180000 clears the dimensions, the control word, the start-of-screen offset, the pointer position, all three tables and the interrupt.
- R12: Writes to 0x080000 and to the timing offsets 0x080108-0x080170 and 0x080200 change nothing and raise no error. Reads there return zero and pulse the error output.
- R13: A read of an unmapped address returns zero. A write to an unmapped address changes nothing. Both pulse the error output. Read data and the error output are registered and appear in the cycle after the access.
- R14: A frame-done pulse sets the interrupt in the next cycle. Any accepted write clears it in the next cycle. When both happen in the same cycle, the frame-done pulse wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| bus_addr | input | 21 | Byte address |
| bus_wdata | input | 32 | Write data, sub-word data in the low bits |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle error pulse for a bad access |
| frame_done | input | 1 | End-of-frame pulse from the display engine |
| irq | output | 1 | Level interrupt |
| pix_width | output | 16 | Active width in pixels |
| pix_height | output | 16 | Active height in lines |
| screen_top | output | 32 | Start-of-screen offset |
| blank | output | 1 | Forced blanking |
| cursor_en | output | 1 | Pointer overlay enabled |
| depth_bits | output | 5 | Decoded pixel depth |
| cursor_x | output | 12 | Pointer X |
| cursor_y | output | 12 | Pointer Y |
| pix_index | input | 8 | Colour table lookup index |
| pix_rgb | output | 24 | Colour table lookup result |
| cur_sel | input | 2 | Pointer colour lookup index |
| cur_rgb | output | 24 | Pointer colour lookup result |
| cur_row | input | 9 | Pointer bitmap lookup index |
| cur_bits | output | 16 | Pointer bitmap lookup result |

## Verification
The colour table is swept over all 256 entries with distinct per-channel values, so any index aliasing or channel swap shows up. The pointer bitmap is swept over all 512 words with halfword writes, which separates correct lane merging from a plain word store. The depth field is swept over all eight codes with the blank and pointer-disable bits toggled against it, which tells apart a wrong table value from a wrong bit position. Scaled dimensions are tried with odd and all-ones values, where truncation and overflow differ from a plain store. Timing writes, unmapped accesses and an interrupt set and clear in the same cycle separate "ignored" from "error", and show which source wins the interrupt.

// File: rtl/fbreg_pkg.sv
package fbreg_pkg;

  localparam int ADDR_W = 21;

  localparam logic [31:0] OFF_IDENT  = 32'h0000_0000;
  localparam logic [31:0] OFF_BOOT   = 32'h0008_0000;
  localparam logic [31:0] OFF_HDISP  = 32'h0008_0118;
  localparam logic [31:0] OFF_VDISP  = 32'h0008_0150;
  localparam logic [31:0] OFF_CTRL   = 32'h0008_0300;
  localparam logic [31:0] OFF_TOP    = 32'h0008_0400;
  localparam logic [31:0] OFF_CPAL   = 32'h0008_0508;
  localparam logic [31:0] OFF_CPOS   = 32'h0008_0638;
  localparam logic [31:0] OFF_PAL    = 32'h0008_0800;
  localparam logic [31:0] OFF_PAT    = 32'h0008_1000;
  localparam logic [31:0] OFF_CLEAR  = 32'h0018_0000;

  localparam logic [31:0] IDENT_VALUE = 32'h0000_0010;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_IDENT,
    RG_TIMING,
    RG_HDISP,
    RG_VDISP,
    RG_CTRL,
    RG_TOP,
    RG_CPOS,
    RG_CPAL,
    RG_PAL,
    RG_PAT,
    RG_CLEAR
  } region_e;

  // Control word field positions
  localparam int CTRL_BLANK_BIT  = 10;
  localparam int CTRL_NOCURS_BIT = 23;
  localparam int CTRL_DEPTH_LSB  = 20;

  function automatic logic [4:0] depth_of(input logic [2:0] code);
    logic [4:0] d;
    case (code)
      3'd0:    d = 5'd1;
      3'd1:    d = 5'd2;
      3'd2:    d = 5'd4;
      3'd3:    d = 5'd8;
      3'd4:    d = 5'd15;
      3'd5:    d = 5'd16;
      default: d = 5'd0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/fbreg_decode.sv
module fbreg_decode
  import fbreg_pkg::*;
#(
  parameter int PAL_ENTRIES  = 256,
  parameter int CPAL_ENTRIES = 3,
  parameter int PAT_WORDS    = 512
) (
  input  logic [ADDR_W-1:0]               addr,
  output region_e                         region,
  output logic [$clog2(PAL_ENTRIES)-1:0]  pal_idx,
  output logic [$clog2(CPAL_ENTRIES)-1:0] cpal_idx,
  output logic [$clog2(PAT_WORDS)-1:0]    pat_idx
);

  localparam int PAL_IDX_W  = $clog2(PAL_ENTRIES);
  localparam int CPAL_IDX_W = $clog2(CPAL_ENTRIES);
  localparam int PAT_IDX_W  = $clog2(PAT_WORDS);
  localparam logic [31:0] PAL_END  = OFF_PAL  + 32'(PAL_ENTRIES * 8);
  localparam logic [31:0] CPAL_END = OFF_CPAL + 32'(CPAL_ENTRIES * 8);
  localparam logic [31:0] PAT_END  = OFF_PAT  + 32'(PAT_WORDS * 8);

  logic [31:0] wa;
  logic [31:0] pal_off;
  logic [31:0] cpal_off;
  logic [31:0] pat_off;

  // Word-aligned view of the byte address
  assign wa       = {{(32-ADDR_W){1'b0}}, addr[ADDR_W-1:2], 2'b00};
  assign pal_off  = wa - OFF_PAL;
  assign cpal_off = wa - OFF_CPAL;
  assign pat_off  = wa - OFF_PAT;

  // Tables use an 8-byte stride
  assign pal_idx  = pal_off[3 +: PAL_IDX_W];
  assign cpal_idx = cpal_off[3 +: CPAL_IDX_W];
  assign pat_idx  = pat_off[3 +: PAT_IDX_W];

  always_comb begin
    region = RG_NONE;
    case (wa)
      OFF_IDENT: region = RG_IDENT;
      OFF_HDISP: region = RG_HDISP;
      OFF_VDISP: region = RG_VDISP;
      OFF_CTRL:  region = RG_CTRL;
      OFF_TOP:   region = RG_TOP;
      OFF_CPOS:  region = RG_CPOS;
      OFF_CLEAR: region = RG_CLEAR;
      OFF_BOOT,
      32'h0008_0108, 32'h0008_0110, 32'h0008_0120, 32'h0008_0128,
      32'h0008_0130, 32'h0008_0138, 32'h0008_0140, 32'h0008_0148,
      32'h0008_0158, 32'h0008_0160, 32'h0008_0168, 32'h0008_0170,
      32'h0008_0200: region = RG_TIMING;
      default: begin
        if (wa >= OFF_PAL && wa < PAL_END) begin
          region = RG_PAL;
        end else if (wa >= OFF_CPAL && wa < CPAL_END) begin
          region = RG_CPAL;
        end else if (wa >= OFF_PAT && wa < PAT_END) begin
          region = RG_PAT;
        end else begin
          region = RG_NONE;
        end
      end
    endcase
  end

endmodule

// File: rtl/fbreg_lane.sv
module fbreg_lane (
  input  logic [1:0]  size,
  input  logic [1:0]  lane,
  input  logic [31:0] cur_word,
  input  logic [31:0] wdata,
  output logic [31:0] merged,
  output logic [31:0] rd_lane
);

  logic [4:0] bsh;
  assign bsh = {lane, 3'b000};

  always_comb begin
    merged  = cur_word;
    rd_lane = cur_word;
    if (size[1]) begin
      merged  = wdata;
      rd_lane = cur_word;
    end else if (size[0]) begin
      if (lane[1]) begin
        merged  = {wdata[15:0], cur_word[15:0]};
        rd_lane = {16'h0000, cur_word[31:16]};
      end else begin
        merged  = {cur_word[31:16], wdata[15:0]};
        rd_lane = {16'h0000, cur_word[15:0]};
      end
    end else begin
      merged         = cur_word;
      merged[bsh +: 8] = wdata[7:0];
      rd_lane        = {24'h000000, cur_word[bsh +: 8]};
    end
  end

endmodule

// File: rtl/fbreg_store.sv
module fbreg_store #(
  parameter int PAL_ENTRIES  = 256,
  parameter int CPAL_ENTRIES = 3,
  parameter int PAT_WORDS    = 512
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic [31:0]                     wword,
  input  logic                            pal_we,
  input  logic [$clog2(PAL_ENTRIES)-1:0]  pal_widx,
  input  logic                            cpal_we,
  input  logic [$clog2(CPAL_ENTRIES)-1:0] cpal_widx,
  input  logic                            pat_we,
  input  logic [$clog2(PAT_WORDS)-1:0]    pat_widx,
  output logic [23:0]                     pal_rdata,
  output logic [23:0]                     cpal_rdata,
  output logic [15:0]                     pat_rdata,
  input  logic [$clog2(PAL_ENTRIES)-1:0]  pix_index,
  output logic [23:0]                     pix_rgb,
  input  logic [$clog2(CPAL_ENTRIES)-1:0] cur_sel,
  output logic [23:0]                     cur_rgb,
  input  logic [$clog2(PAT_WORDS)-1:0]    cur_row,
  output logic [15:0]                     cur_bits
);

  localparam int PAL_IDX_W  = $clog2(PAL_ENTRIES);
  localparam int CPAL_IDX_W = $clog2(CPAL_ENTRIES);
  localparam int PAT_IDX_W  = $clog2(PAT_WORDS);

  logic [23:0] pal_q  [PAL_ENTRIES];
  logic [23:0] cpal_q [CPAL_ENTRIES];
  logic [15:0] pat_q  [PAT_WORDS];

  for (genvar i = 0; i < PAL_ENTRIES; i++) begin : g_pal
    logic en;
    assign en = pal_we && (pal_widx == PAL_IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pal_q[i] <= '0;
      else if (clr)   pal_q[i] <= '0;
      else if (en)    pal_q[i] <= wword[23:0];
    end
  end

  for (genvar k = 0; k < CPAL_ENTRIES; k++) begin : g_cpal
    logic en;
    assign en = cpal_we && (cpal_widx == CPAL_IDX_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cpal_q[k] <= '0;
      else if (clr)   cpal_q[k] <= '0;
      else if (en)    cpal_q[k] <= wword[23:0];
    end
  end

  for (genvar j = 0; j < PAT_WORDS; j++) begin : g_pat
    logic en;
    assign en = pat_we && (pat_widx == PAT_IDX_W'(j));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pat_q[j] <= '0;
      else if (clr)   pat_q[j] <= '0;
      else if (en)    pat_q[j] <= wword[15:0];
    end
  end

  // Bus-side reads share the write index
  assign pal_rdata  = pal_q[pal_widx];
  assign cpal_rdata = (32'(cpal_widx) < CPAL_ENTRIES) ? cpal_q[cpal_widx] : 24'h0;
  assign pat_rdata  = pat_q[pat_widx];

  // Pixel-side lookups
  assign pix_rgb  = pal_q[pix_index];
  assign cur_rgb  = (32'(cur_sel) < CPAL_ENTRIES) ? cpal_q[cur_sel] : 24'h0;
  assign cur_bits = pat_q[cur_row];

endmodule

// File: rtl/fbreg_ctrl.sv
module fbreg_ctrl
  import fbreg_pkg::*;
#(
  parameter int DIM_W        = 16,
  parameter int PAL_ENTRIES  = 256,
  parameter int CPAL_ENTRIES = 3,
  parameter int PAT_WORDS    = 512
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_valid,
  input  logic                            bus_write,
  input  logic [1:0]                      bus_size,
  input  logic [20:0]                     bus_addr,
  input  logic [31:0]                     bus_wdata,
  output logic [31:0]                     bus_rdata,
  output logic                            bus_err,
  input  logic                            frame_done,
  output logic                            irq,
  output logic [DIM_W-1:0]                pix_width,
  output logic [DIM_W-1:0]                pix_height,
  output logic [31:0]                     screen_top,
  output logic                            blank,
  output logic                            cursor_en,
  output logic [4:0]                      depth_bits,
  output logic [11:0]                     cursor_x,
  output logic [11:0]                     cursor_y,
  input  logic [$clog2(PAL_ENTRIES)-1:0]  pix_index,
  output logic [23:0]                     pix_rgb,
  input  logic [$clog2(CPAL_ENTRIES)-1:0] cur_sel,
  output logic [23:0]                     cur_rgb,
  input  logic [$clog2(PAT_WORDS)-1:0]    cur_row,
  output logic [15:0]                     cur_bits
);

  localparam int PAL_IDX_W  = $clog2(PAL_ENTRIES);
  localparam int CPAL_IDX_W = $clog2(CPAL_ENTRIES);
  localparam int PAT_IDX_W  = $clog2(PAT_WORDS);

  region_e                region;
  logic [PAL_IDX_W-1:0]   pal_idx;
  logic [CPAL_IDX_W-1:0]  cpal_idx;
  logic [PAT_IDX_W-1:0]   pat_idx;
  logic [23:0]            pal_rdata;
  logic [23:0]            cpal_rdata;
  logic [15:0]            pat_rdata;
  logic [31:0]            cur_word;
  logic [31:0]            merged;
  logic [31:0]            rd_lane;

  logic acc_wr;
  logic acc_rd;
  logic rd_bad;
  logic clr;

  logic [DIM_W-1:0] width_q,  width_n;
  logic [DIM_W-1:0] height_q, height_n;
  logic [31:0]      ctrl_q,   ctrl_n;
  logic [31:0]      top_q,    top_n;
  logic [23:0]      cpos_q,   cpos_n;
  logic             irq_q,    irq_n;
  logic [31:0]      rdata_q,  rdata_n;
  logic             err_q,    err_n;

  fbreg_decode #(
    .PAL_ENTRIES (PAL_ENTRIES),
    .CPAL_ENTRIES(CPAL_ENTRIES),
    .PAT_WORDS   (PAT_WORDS)
  ) u_decode (
    .addr    (bus_addr),
    .region  (region),
    .pal_idx (pal_idx),
    .cpal_idx(cpal_idx),
    .pat_idx (pat_idx)
  );

  assign acc_wr = bus_valid &&  bus_write;
  assign acc_rd = bus_valid && !bus_write;
  assign clr    = acc_wr && (region == RG_CLEAR);
  assign rd_bad = (region == RG_NONE) || (region == RG_TIMING) || (region == RG_CLEAR);

  fbreg_store #(
    .PAL_ENTRIES (PAL_ENTRIES),
    .CPAL_ENTRIES(CPAL_ENTRIES),
    .PAT_WORDS   (PAT_WORDS)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .wword     (merged),
    .pal_we    (acc_wr && (region == RG_PAL)),
    .pal_widx  (pal_idx),
    .cpal_we   (acc_wr && (region == RG_CPAL)),
    .cpal_widx (cpal_idx),
    .pat_we    (acc_wr && (region == RG_PAT)),
    .pat_widx  (pat_idx),
    .pal_rdata (pal_rdata),
    .cpal_rdata(cpal_rdata),
    .pat_rdata (pat_rdata),
    .pix_index (pix_index),
    .pix_rgb   (pix_rgb),
    .cur_sel   (cur_sel),
    .cur_rgb   (cur_rgb),
    .cur_row   (cur_row),
    .cur_bits  (cur_bits)
  );

  // Current full-word view of the addressed register
  always_comb begin
    case (region)
      RG_IDENT: cur_word = IDENT_VALUE;
      RG_HDISP: cur_word = 32'(width_q >> 2);
      RG_VDISP: cur_word = 32'({width_zero_pad(height_q), 1'b0});
      RG_CTRL:  cur_word = ctrl_q;
      RG_TOP:   cur_word = top_q;
      RG_CPOS:  cur_word = {8'h00, cpos_q};
      RG_CPAL:  cur_word = {8'h00, cpal_rdata};
      RG_PAL:   cur_word = {8'h00, pal_rdata};
      RG_PAT:   cur_word = {16'h0000, pat_rdata};
      default:  cur_word = 32'h0;
    endcase
  end

  function automatic logic [DIM_W-1:0] width_zero_pad(input logic [DIM_W-1:0] v);
    return v;
  endfunction

  fbreg_lane u_lane (
    .size    (bus_size),
    .lane    (bus_addr[1:0]),
    .cur_word(cur_word),
    .wdata   (bus_wdata),
    .merged  (merged),
    .rd_lane (rd_lane)
  );

  // Next-state logic
  always_comb begin
    width_n  = width_q;
    height_n = height_q;
    ctrl_n   = ctrl_q;
    top_n    = top_q;
    cpos_n   = cpos_q;
    irq_n    = irq_q;
    rdata_n  = rdata_q;
    err_n    = 1'b0;

    if (acc_rd) begin
      if (rd_bad) begin
        rdata_n = 32'h0;
        err_n   = 1'b1;
      end else begin
        rdata_n = rd_lane;
      end
    end

    if (acc_wr) begin
      case (region)
        RG_HDISP: width_n  = {merged[DIM_W-3:0], 2'b00};
        RG_VDISP: height_n = merged[DIM_W:1];
        RG_CTRL:  ctrl_n   = merged;
        RG_TOP:   top_n    = merged;
        RG_CPOS:  cpos_n   = merged[23:0];
        RG_CLEAR: begin
          width_n  = '0;
          height_n = '0;
          ctrl_n   = '0;
          top_n    = '0;
          cpos_n   = '0;
        end
        RG_NONE:  err_n    = 1'b1;
        default:  ;
      endcase
      irq_n = 1'b0;
    end

    if (frame_done) begin
      irq_n = 1'b1;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q  <= '0;
      height_q <= '0;
      ctrl_q   <= '0;
      top_q    <= '0;
      cpos_q   <= '0;
      irq_q    <= 1'b0;
      rdata_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      width_q  <= width_n;
      height_q <= height_n;
      ctrl_q   <= ctrl_n;
      top_q    <= top_n;
      cpos_q   <= cpos_n;
      irq_q    <= irq_n;
      rdata_q  <= rdata_n;
      err_q    <= err_n;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_err    = err_q;
  assign irq        = irq_q;
  assign pix_width  = width_q;
  assign pix_height = height_q;
  assign screen_top = top_q;
  assign blank      = ctrl_q[CTRL_BLANK_BIT];
  assign cursor_en  = !ctrl_q[CTRL_NOCURS_BIT];
  assign depth_bits = depth_of(ctrl_q[CTRL_DEPTH_LSB +: 3]);
  assign cursor_x   = cpos_q[23:12];
  assign cursor_y   = cpos_q[11:0];

endmodule

// File: rtl/fbreg_ctrl_chk.sv
module fbreg_ctrl_chk #(
  parameter int DIM_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [1:0]       bus_size,
  input logic [20:0]      bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             bus_err,
  input logic             frame_done,
  input logic             irq,
  input logic [DIM_W-1:0] pix_width,
  input logic [DIM_W-1:0] pix_height,
  input logic             blank,
  input logic [4:0]       depth_bits
);

  logic [20:0] wa;
  assign wa = {bus_addr[20:2], 2'b00};

  // R14: frame-done sets the interrupt
  p_irq_set_r14: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> irq);

  // R14: a write without frame-done clears it
  p_irq_clr_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && !frame_done) |=> !irq);

  // R14: interrupt only rises after frame-done
  p_irq_rise_r14: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(frame_done));

  // R13: error pulses only follow an access
  p_err_src_r13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_valid));

  // R3: horizontal register scales by four
  p_hdisp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_size[1] && wa == 21'h080118)
      |=> pix_width == DIM_W'({$past(bus_wdata), 2'b00}));

  // R11: clear address empties the dimensions and interrupt
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && wa == 21'h180000 && !frame_done)
      |=> (pix_width == '0 && pix_height == '0 && !irq));

  // R5: depth only takes table values
  p_depth_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_bits == 5'd0 || depth_bits == 5'd1 || depth_bits == 5'd2 ||
     depth_bits == 5'd4 || depth_bits == 5'd8 || depth_bits == 5'd15 ||
     depth_bits == 5'd16));

  // R5: blanking only moves after a write
  p_blank_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_valid && bus_write) |-> $stable(blank));

endmodule

bind fbreg_ctrl fbreg_ctrl_chk #(.DIM_W(DIM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_size  (bus_size),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_err   (bus_err),
  .frame_done(frame_done),
  .irq       (irq),
  .pix_width (pix_width),
  .pix_height(pix_height),
  .blank     (blank),
  .depth_bits(depth_bits)
);

// File: tb/fbreg_ctrl_test.sv
module fbreg_ctrl_test;

  logic        clk;
  logic        rst_n;
  logic        bus_valid;
  logic        bus_write;
  logic [1:0]  bus_size;
  logic [20:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        frame_done;
  logic        irq;
  logic [15:0] pix_width;
  logic [15:0] pix_height;
  logic [31:0] screen_top;
  logic        blank;
  logic        cursor_en;
  logic [4:0]  depth_bits;
  logic [11:0] cursor_x;
  logic [11:0] cursor_y;
  logic [7:0]  pix_index;
  logic [23:0] pix_rgb;
  logic [1:0]  cur_sel;
  logic [23:0] cur_rgb;
  logic [8:0]  cur_row;
  logic [15:0] cur_bits;

  int checks;
  int fails;

  fbreg_ctrl uut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [20:0] a, input logic [1:0] sz,
                        input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1;
    bus_write = w;
    bus_addr  = a;
    bus_size  = sz;
    bus_wdata = d;
    @(posedge clk);
    #1;
    bus_valid = 1'b0;
    bus_write = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [20:0] a, input logic [1:0] sz, input logic [31:0] d);
    access(1'b1, a, sz, d);
  endtask

  task automatic rd(input logic [20:0] a, input logic [1:0] sz, input logic [31:0] exp,
                    input string tag);
    access(1'b0, a, sz, 32'h0);
    chk(tag, bus_rdata, exp);
  endtask

  function automatic logic [4:0] exp_depth(input int code);
    case (code)
      0: return 5'd1;
      1: return 5'd2;
      2: return 5'd4;
      3: return 5'd8;
      4: return 5'd15;
      5: return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [23:0] pal_val(input int i);
    logic [7:0] b;
    b = 8'(i);
    return {b, ~b, b ^ 8'h5A};
  endfunction

  function automatic logic [15:0] pat_val(input int j);
    return 16'((j * 37) ^ 32'h5A5A);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0;
    fails = 0;
    rst_n = 1'b0;
    bus_valid = 1'b0;
    bus_write = 1'b0;
    bus_size = 2'd2;
    bus_addr = '0;
    bus_wdata = '0;
    frame_done = 1'b0;
    pix_index = '0;
    cur_sel = '0;
    cur_row = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 width", 32'(pix_width), 0);
    chk("R1 height", 32'(pix_height), 0);
    chk("R1 depth", 32'(depth_bits), 1);
    chk("R1 cursor_en", 32'(cursor_en), 1);
    chk("R1 blank", 32'(blank), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 top", screen_top, 0);
    chk("R1 pal", 32'(pix_rgb), 0);

    // R2 identity, R10 lane reads
    rd(21'h000000, 2'd2, 32'h10, "R2 ident word");
    chk("R2 no err", 32'(bus_err), 0);
    rd(21'h000000, 2'd0, 32'h10, "R10 ident byte0");
    rd(21'h000001, 2'd0, 32'h00, "R10 ident byte1");
    rd(21'h000002, 2'd1, 32'h00, "R10 ident half1");
    wr(21'h000000, 2'd2, 32'hFFFF_FFFF);
    chk("R2 write no err", 32'(bus_err), 0);
    rd(21'h000000, 2'd2, 32'h10, "R2 ident after write");

    // R3 horizontal scaling
    wr(21'h080118, 2'd2, 32'h140);
    chk("R3 width", 32'(pix_width), 1280);
    rd(21'h080118, 2'd2, 32'h140, "R3 read");
    wr(21'h080118, 2'd2, 32'hFFFF_FFFF);
    chk("R3 width max", 32'(pix_width), 32'hFFFC);
    rd(21'h080118, 2'd2, 32'h3FFF, "R3 read max");

    // R4 vertical scaling
    wr(21'h080150, 2'd2, 32'd7);
    chk("R4 height odd", 32'(pix_height), 3);
    rd(21'h080150, 2'd2, 32'd6, "R4 read odd");
    wr(21'h080150, 2'd2, 32'h1FFFF);
    chk("R4 height max", 32'(pix_height), 32'hFFFF);
    rd(21'h080150, 2'd2, 32'h1FFFE, "R4 read max");

    // R5 control word sweep
    for (int c = 0; c < 8; c++) begin
      logic [31:0] cw;
      cw = (32'(c) << 20) | ((c % 2 == 1) ? 32'h400 : 0) |
           ((c >= 4) ? 32'h0080_0000 : 0) | 32'h0000_0003;
      wr(21'h080300, 2'd2, cw);
      chk($sformatf("R5 depth code %0d", c), 32'(depth_bits), 32'(exp_depth(c)));
      chk($sformatf("R5 blank code %0d", c), 32'(blank), (c % 2 == 1) ? 1 : 0);
      chk($sformatf("R5 cursor_en code %0d", c), 32'(cursor_en), (c >= 4) ? 0 : 1);
      rd(21'h080300, 2'd2, cw, "R5 readback");
    end
    wr(21'h080300, 2'd2, 32'hA5C3_5A3C);
    rd(21'h080302, 2'd1, 32'hA5C3, "R10 ctrl half1");
    rd(21'h080301, 2'd0, 32'h5A, "R10 ctrl byte1");

    // R6 colour table sweep
    for (int i = 0; i < 256; i++) begin
      wr(21'h080800 + 21'(i * 8), 2'd2, {8'hA5, pal_val(i)});
    end
    for (int i = 0; i < 256; i++) begin
      rd(21'h080800 + 21'(i * 8), 2'd2, {8'h00, pal_val(i)}, "R6 pal read");
      pix_index = 8'(i);
      #1;
      chk("R6 pal lookup", 32'(pix_rgb), 32'(pal_val(i)));
    end

    // R9 byte merge into colour entry 7 (green lane)
    wr(21'h080809 + 21'(6 * 8), 2'd0, 32'hFFFF_FF33);
    rd(21'h080838, 2'd2, {8'h00, pal_val(7)[23:16], 8'h33, pal_val(7)[7:0]},
       "R9 byte merge pal");

    // R7 pointer colours
    for (int k = 0; k < 3; k++) begin
      wr(21'h080508 + 21'(k * 8), 2'd2, 32'hFF00_0000 | (32'h10_2030 * (k + 1)));
    end
    for (int k = 0; k < 3; k++) begin
      rd(21'h080508 + 21'(k * 8), 2'd2, 32'h10_2030 * (k + 1), "R7 cpal read");
      cur_sel = 2'(k);
      #1;
      chk("R7 cpal lookup", 32'(cur_rgb), 32'h10_2030 * (k + 1));
    end

    // R7 and R9 pointer bitmap by halfword writes
    for (int j = 0; j < 512; j++) begin
      wr(21'h081000 + 21'(j * 8), 2'd1, {16'hFFFF, pat_val(j)});
    end
    for (int j = 0; j < 512; j++) begin
      rd(21'h081000 + 21'(j * 8), 2'd2, {16'h0, pat_val(j)}, "R7 pat read");
      cur_row = 9'(j);
      #1;
      chk("R7 pat lookup", 32'(cur_bits), 32'(pat_val(j)));
    end
    wr(21'h081002 + 21'(3 * 8), 2'd1, 32'h1234);
    rd(21'h081000 + 21'(3 * 8), 2'd2, {16'h0, pat_val(3)}, "R9 upper half dropped");
    wr(21'h081001 + 21'(4 * 8), 2'd0, 32'hCD);
    rd(21'h081000 + 21'(4 * 8), 2'd2, {16'h0, 8'hCD, pat_val(4)[7:0]}, "R9 byte lane1 pat");

    // R8 start-of-screen and pointer position
    wr(21'h080400, 2'd2, 32'h1122_3344);
    wr(21'h080403, 2'd0, 32'h5E);
    chk("R8 R9 top byte3", screen_top, 32'h5E22_3344);
    rd(21'h080400, 2'd2, 32'h5E22_3344, "R8 top read");
    wr(21'h080638, 2'd2, 32'hFFAB_C123);
    chk("R8 cursor x", 32'(cursor_x), 32'hABC);
    chk("R8 cursor y", 32'(cursor_y), 32'h123);
    rd(21'h080638, 2'd2, 32'h00AB_C123, "R8 cpos read");

    // R12 timing offsets
    wr(21'h080000, 2'd2, 32'hFFFF_FFFF);
    chk("R12 boot no err", 32'(bus_err), 0);
    wr(21'h080108, 2'd2, 32'hFFFF_FFFF);
    chk("R12 timing no err", 32'(bus_err), 0);
    wr(21'h080200, 2'd2, 32'hFFFF_FFFF);
    chk("R12 mask no err", 32'(bus_err), 0);
    chk("R12 width kept", 32'(pix_width), 32'hFFFC);
    rd(21'h080118, 2'd2, 32'h3FFF, "R12 hdisp kept");
    rd(21'h080300, 2'd2, 32'hA5C3_5A3C, "R12 ctrl kept");
    rd(21'h080108, 2'd2, 32'h0, "R12 timing read zero");
    chk("R12 timing read err", 32'(bus_err), 1);

    // R13 unmapped accesses
    wr(21'h000100, 2'd2, 32'hFFFF_FFFF);
    chk("R13 wr err", 32'(bus_err), 1);
    @(negedge clk);
    chk("R13 err one cycle", 32'(bus_err), 0);
    rd(21'h100000, 2'd2, 32'h0, "R13 unmapped read");
    chk("R13 rd err", 32'(bus_err), 1);
    rd(21'h080400, 2'd2, 32'h5E22_3344, "R13 top unchanged");

    // R14 interrupt
    @(negedge clk);
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    chk("R14 irq set", 32'(irq), 1);
    wr(21'h000100, 2'd2, 32'h0);
    chk("R14 irq clear", 32'(irq), 0);
    @(negedge clk);
    frame_done = 1'b1;
    bus_valid = 1'b1;
    bus_write = 1'b1;
    bus_addr = 21'h080400;
    bus_size = 2'd2;
    bus_wdata = 32'h0000_0042;
    @(negedge clk);
    frame_done = 1'b0;
    bus_valid = 1'b0;
    bus_write = 1'b0;
    chk("R14 frame wins", 32'(irq), 1);

    // R11 clear address
    wr(21'h180000, 2'd2, 32'h0);
    chk("R11 irq", 32'(irq), 0);
    chk("R11 width", 32'(pix_width), 0);
    chk("R11 height", 32'(pix_height), 0);
    chk("R11 top", screen_top, 0);
    chk("R11 cursor", {8'h0, cursor_x, cursor_y}, 0);
    chk("R11 depth", 32'(depth_bits), 1);
    rd(21'h080300, 2'd2, 32'h0, "R11 ctrl");
    rd(21'h080828, 2'd2, 32'h0, "R11 pal entry5");
    rd(21'h081000, 2'd2, 32'h0, "R11 pat entry0");
    rd(21'h080510, 2'd2, 32'h0, "R11 cpal entry1");
    pix_index = 8'd200;
    #1;
    chk("R11 pal lookup", 32'(pix_rgb), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule